// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer for a 32-bit core. Each of its entries describes a pair of adjacent virtual pages, an even one and an odd one, that share one virtual tag, one address-space identifier and one page size. Each half of the pair has its own physical frame, valid bit and dirty bit. A per-entry page mask sets the size of the pair. The smallest pair is two 4 KB pages, so 1 KB pages cannot be expressed.

A request presents a virtual address, the current address-space identifier and a store flag. The unit compares the request against every entry in the same cycle. It registers the outcome, so the result appears one clock later. The outcome is a status code, a physical address and read/write permission bits. It also reports the index of the entry that matched and a flag that is raised when more than one entry matched.

A separate write port loads one whole entry by index. Refill policy and random index selection are the job of the logic around this unit.

Top module: `paired_tlb`

## Requirements
- R1: An entry matches a request when the address bits above its effective mask equal the same bits of its stored virtual tag, and either its global bit is set or its 8-bit identifier equals the request identifier.
- R2: The effective mask of an entry is its 16-bit mask field placed on address bits 28..13, ORed with 0x1FFF. With a mask of zero an entry covers two 4 KB pages.
- R3: The half is selected by the top set bit of the effective mask. If that address bit is 1, the odd half (frame 1, valid 1, dirty 1) is used; otherwise the even half is used.
- R4: A matching request whose selected half is not valid returns status INVALID (code 2), physical address 0 and no permissions.
- R5: A load, or a store to a half whose dirty bit is set, returns status HIT (code 0). The physical address is the half's frame ORed with the address bits under half the effective mask.
- R6: A store to a valid half whose dirty bit is clear returns status MODIFIED (code 3), physical address 0 and no permissions.
- R7: When no entry matches, the status is MISS (code 1), the physical address is 0 and the index is 0.
- R8: On HIT the read permission is 1. The write permission equals the selected half's dirty bit. On any other status both permissions are 0.
- R9: When several entries match, the lowest-indexed one supplies the result and its index, and the multi-hit flag is 1. Otherwise the multi-hit flag is 0.
- R10: The result registers load on the clock edge that samples a request, and the result-valid output follows the request-valid input one cycle later. A request in the same cycle as a write sees the entry contents from before the write.
- R11: Reset clears all entries and sets result-valid to 0, status to MISS, address 0 and index 0. A write replaces every field of the indexed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write one entry this cycle |
| wrIdx | input | 4 | Entry index to write |
| wrVpn | input | 32 | Virtual tag of the page pair (bits under the mask are ignored) |
| wrAsid | input | 8 | Address-space identifier of the entry |
| wrGlobal | input | 1 | Entry matches any identifier |
| wrMask | input | 16 | Page mask, covering address bits 28..13 |
| wrFrame0 | input | 32 | Physical base of the even page |
| wrFrame1 | input | 32 | Physical base of the odd page |
| wrValid0 | input | 1 | Even page valid |
| wrValid1 | input | 1 | Odd page valid |
| wrDirty0 | input | 1 | Even page writable |
| wrDirty1 | input | 1 | Odd page writable |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkAsid | input | 8 | Current address-space identifier |
| lkStore | input | 1 | 1 for a store, 0 for a load |
| rspValid | output | 1 | Result of the previous cycle's request is present |
| rspStatus | output | 2 | 0 HIT, 1 MISS, 2 INVALID, 3 MODIFIED |
| rspPaddr | output | 32 | Translated address, 0 unless HIT |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspMultiHit | output | 1 | More than one entry matched |
| rspIndex | output | 4 | Index of the winning entry (probe result) |

## Verification
The properties assume three things about the inputs. Mask fields are contiguous runs of ones from bit 0. Frame bases have zero bits below their page size. The address identifier and store flag are steady for the cycle they are sampled. The stimulus keeps to these rules: it uses only the masks 0 and 0x0003 and frame bases aligned to 16 KB or more. It also spreads entries across distinct tags, except for one deliberate pair that overlaps to exercise the multi-hit priority. Addresses near zero are never looked up, so the cleared, never-written entries do not take part in any match.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [1:0] {
    TLB_HIT      = 2'd0,
    TLB_MISS     = 2'd1,
    TLB_INVALID  = 2'd2,
    TLB_MODIFIED = 2'd3
  } tlbStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load result registers this edge
    logic grant;    // translation allowed, expose address
  } tlbStrobe_t;
endpackage

// File: rtl/ptlb_datapath.sv
module ptlb_datapath
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 16,
  parameter int MIN_OFF = 13,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int HIGH_W = ADDR_W - MIN_OFF - MASK_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [ADDR_W-1:0]   wrVpn,
  input  logic [ASID_W-1:0]   wrAsid,
  input  logic                wrGlobal,
  input  logic [MASK_W-1:0]   wrMask,
  input  logic [ADDR_W-1:0]   wrFrame0,
  input  logic [ADDR_W-1:0]   wrFrame1,
  input  logic                wrValid0,
  input  logic                wrValid1,
  input  logic                wrDirty0,
  input  logic                wrDirty1,
  input  logic [ADDR_W-1:0]   lkAddr,
  input  logic [ASID_W-1:0]   lkAsid,
  input  tlbStrobe_t          ctl,
  input  logic [IDX_W-1:0]    selIdx,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  halfValid,
  output logic [ENTRIES-1:0]  halfDirty,
  output logic [ADDR_W-1:0]   paddrQ
);
  logic [ADDR_W-1:0] vpnQ    [ENTRIES];
  logic [ASID_W-1:0] asidQ   [ENTRIES];
  logic [MASK_W-1:0] maskQ   [ENTRIES];
  logic [ADDR_W-1:0] frame0Q [ENTRIES];
  logic [ADDR_W-1:0] frame1Q [ENTRIES];
  logic [ENTRIES-1:0] globalQ, valid0Q, valid1Q, dirty0Q, dirty1Q;
  logic [ADDR_W-1:0] physCand [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]    <= '0;
        asidQ[i]   <= '0;
        maskQ[i]   <= '0;
        frame0Q[i] <= '0;
        frame1Q[i] <= '0;
      end
      globalQ <= '0;
      valid0Q <= '0;
      valid1Q <= '0;
      dirty0Q <= '0;
      dirty1Q <= '0;
    end else if (wrEn) begin
      vpnQ[wrIdx]    <= wrVpn;
      asidQ[wrIdx]   <= wrAsid;
      maskQ[wrIdx]   <= wrMask;
      frame0Q[wrIdx] <= wrFrame0;
      frame1Q[wrIdx] <= wrFrame1;
      globalQ[wrIdx] <= wrGlobal;
      valid0Q[wrIdx] <= wrValid0;
      valid1Q[wrIdx] <= wrValid1;
      dirty0Q[wrIdx] <= wrDirty0;
      dirty1Q[wrIdx] <= wrDirty1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [ADDR_W-1:0] effMask, halfMask, topBit;
    logic oddSel, tagEq, idEq;
    assign effMask  = {{HIGH_W{1'b0}}, maskQ[g], {MIN_OFF{1'b1}}};
    assign halfMask = effMask >> 1;
    assign topBit   = effMask & ~halfMask;
    assign oddSel   = |(lkAddr & topBit);
    assign tagEq    = (lkAddr & ~effMask) == (vpnQ[g] & ~effMask);
    assign idEq     = globalQ[g] || (asidQ[g] == lkAsid);
    assign matchVec[g]  = tagEq && idEq;
    assign halfValid[g] = oddSel ? valid1Q[g] : valid0Q[g];
    assign halfDirty[g] = oddSel ? dirty1Q[g] : dirty0Q[g];
    assign physCand[g]  = (oddSel ? frame1Q[g] : frame0Q[g]) | (lkAddr & halfMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) paddrQ <= '0;
    else if (ctl.capture) paddrQ <= ctl.grant ? physCand[selIdx] : '0;
  end
endmodule

// File: rtl/ptlb_control.sv
module ptlb_control
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               lkStore,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] halfValid,
  input  logic [ENTRIES-1:0] halfDirty,
  output tlbStrobe_t         ctl,
  output logic [IDX_W-1:0]   selIdx,
  output logic               rspValidQ,
  output tlbStatus_e         statusQ,
  output logic               readQ,
  output logic               writeQ,
  output logic               multiQ,
  output logic [IDX_W-1:0]   idxQ
);
  logic anyHit, multiHit, selValid, selDirty, grant;
  tlbStatus_e nextStatus;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        selIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assign multiHit = $countones(matchVec) > 1;
  assign selValid = halfValid[selIdx];
  assign selDirty = halfDirty[selIdx];

  always_comb begin
    if (!anyHit)                   nextStatus = TLB_MISS;
    else if (!selValid)            nextStatus = TLB_INVALID;
    else if (lkStore && !selDirty) nextStatus = TLB_MODIFIED;
    else                           nextStatus = TLB_HIT;
  end

  assign grant       = (nextStatus == TLB_HIT);
  assign ctl.capture = lkValid;
  assign ctl.grant   = grant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      statusQ   <= TLB_MISS;
      readQ     <= 1'b0;
      writeQ    <= 1'b0;
      multiQ    <= 1'b0;
      idxQ      <= '0;
    end else begin
      rspValidQ <= lkValid;
      if (lkValid) begin
        statusQ <= nextStatus;
        readQ   <= grant;
        writeQ  <= grant && selDirty;
        multiQ  <= multiHit;
        idxQ    <= anyHit ? selIdx : '0;
      end
    end
  end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 16,
  parameter int MIN_OFF = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [MASK_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrFrame0,
  input  logic [ADDR_W-1:0] wrFrame1,
  input  logic              wrValid0,
  input  logic              wrValid1,
  input  logic              wrDirty0,
  input  logic              wrDirty1,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkStore,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspMultiHit,
  output logic [IDX_W-1:0]  rspIndex
);
  tlbStrobe_t         ctl;
  tlbStatus_e         statusQ;
  logic [IDX_W-1:0]   selIdx;
  logic [ENTRIES-1:0] matchVec, halfValid, halfDirty;

  ptlb_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ASID_W(ASID_W),
    .MASK_W(MASK_W), .MIN_OFF(MIN_OFF)
  ) uDatapath (
    .clk, .rstN, .wrEn, .wrIdx, .wrVpn, .wrAsid, .wrGlobal, .wrMask,
    .wrFrame0, .wrFrame1, .wrValid0, .wrValid1, .wrDirty0, .wrDirty1,
    .lkAddr, .lkAsid, .ctl, .selIdx, .matchVec, .halfValid, .halfDirty,
    .paddrQ(rspPaddr)
  );

  ptlb_control #(.ENTRIES(ENTRIES)) uControl (
    .clk, .rstN, .lkValid, .lkStore, .matchVec, .halfValid, .halfDirty,
    .ctl, .selIdx, .rspValidQ(rspValid), .statusQ, .readQ(rspRead),
    .writeQ(rspWrite), .multiQ(rspMultiHit), .idxQ(rspIndex)
  );

  assign rspStatus = statusQ;
endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkStore,
  input logic              rspValid,
  input logic [1:0]        rspStatus,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspRead,
  input logic              rspWrite,
  input logic              rspMultiHit
);
  // R10: result valid tracks the request one cycle later
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  // R4, R6, R7: no address leaves unless the status is HIT
  p_paddr_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspStatus != 2'd0) |-> (rspPaddr == '0));
  // R8: permissions only on HIT, write implies read
  p_read_on_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspRead |-> (rspStatus == 2'd0));
  p_write_needs_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> rspRead);
  p_hit_reads_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd0) |-> rspRead);
  // R6: MODIFIED arises only from a store
  p_modified_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) && rspStatus == 2'd3 |-> $past(lkStore));
  // R9: a multi-hit always carries a match
  p_multi_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> (rspStatus != 2'd1));
endmodule

bind paired_tlb ptlb_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkStore(lkStore),
  .rspValid(rspValid), .rspStatus(rspStatus), .rspPaddr(rspPaddr),
  .rspRead(rspRead), .rspWrite(rspWrite), .rspMultiHit(rspMultiHit)
);

// File: tb/sim_paired_tlb.sv
module sim_paired_tlb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_HIT = 2'd0, S_MISS = 2'd1, S_INV = 2'd2, S_MOD = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [15:0] wrMask = '0;
  logic [31:0] wrFrame0 = '0, wrFrame1 = '0;
  logic wrValid0 = 1'b0, wrValid1 = 1'b0, wrDirty0 = 1'b0, wrDirty1 = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkStore = 1'b0;
  logic        rspValid, rspRead, rspWrite, rspMultiHit;
  logic [1:0]  rspStatus;
  logic [31:0] rspPaddr;
  logic [3:0]  rspIndex;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  paired_tlb u0 (
    .clk, .rstN, .wrEn, .wrIdx, .wrVpn, .wrAsid, .wrGlobal, .wrMask,
    .wrFrame0, .wrFrame1, .wrValid0, .wrValid1, .wrDirty0, .wrDirty1,
    .lkValid, .lkAddr, .lkAsid, .lkStore, .rspValid, .rspStatus,
    .rspPaddr, .rspRead, .rspWrite, .rspMultiHit, .rspIndex
  );

  task automatic expectRsp(string req, logic vld, logic [1:0] st, logic [31:0] pa,
                           logic rd, logic wr, logic mh, logic [3:0] idx);
    checks++;
    if (rspValid !== vld || rspStatus !== st || rspPaddr !== pa || rspRead !== rd ||
        rspWrite !== wr || rspMultiHit !== mh || rspIndex !== idx) begin
      fails++;
      $display("FAIL %s: got v=%b st=%0d pa=%h r=%b w=%b m=%b i=%0d, expected v=%b st=%0d pa=%h r=%b w=%b m=%b i=%0d",
               req, rspValid, rspStatus, rspPaddr, rspRead, rspWrite, rspMultiHit, rspIndex,
               vld, st, pa, rd, wr, mh, idx);
    end
  endtask

  task automatic putEntry(logic [3:0] idx, logic [31:0] vpn, logic [7:0] asid, logic glob,
                          logic [15:0] mask, logic [31:0] f0, logic [31:0] f1,
                          logic v0, logic v1, logic d0, logic d1);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrVpn = vpn; wrAsid = asid; wrGlobal = glob; wrMask = mask;
    wrFrame0 = f0; wrFrame1 = f1; wrValid0 = v0; wrValid1 = v1; wrDirty0 = d0; wrDirty1 = d1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(logic [31:0] addr, logic [7:0] asid, logic store);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = addr; lkAsid = asid; lkStore = store;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic testReset();
    expectRsp("R11 reset state", 1'b0, S_MISS, 32'h0, 1'b0, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic testSmallPages();
    putEntry(4'd0, 32'h0000_4000, 8'd5, 1'b0, 16'h0, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0);
    lookup(32'h0000_4123, 8'd5, 1'b0);
    expectRsp("R1 R5 R8 even load", 1, S_HIT, 32'h1000_0123, 1, 1, 0, 4'd0);
    lookup(32'h0000_5456, 8'd5, 1'b0);
    expectRsp("R3 R8 odd load clean", 1, S_HIT, 32'h2000_0456, 1, 0, 0, 4'd0);
    lookup(32'h0000_5456, 8'd5, 1'b1);
    expectRsp("R6 store to clean half", 1, S_MOD, 32'h0, 0, 0, 0, 4'd0);
    lookup(32'h0000_4010, 8'd5, 1'b1);
    expectRsp("R5 store to dirty half", 1, S_HIT, 32'h1000_0010, 1, 1, 0, 4'd0);
    lookup(32'h0000_4123, 8'd6, 1'b0);
    expectRsp("R1 R7 identifier mismatch", 1, S_MISS, 32'h0, 0, 0, 0, 4'd0);
  endtask

  task automatic testLargePages();
    putEntry(4'd1, 32'h0010_0000, 8'd9, 1'b1, 16'h0003, 32'h3000_0000, 32'h3400_0000, 1, 0, 1, 1);
    lookup(32'h0010_2ABC, 8'h33, 1'b0);
    expectRsp("R2 R3 global masked even", 1, S_HIT, 32'h3000_2ABC, 1, 1, 0, 4'd1);
    lookup(32'h0010_4000, 8'h33, 1'b1);
    expectRsp("R4 odd half invalid", 1, S_INV, 32'h0, 0, 0, 0, 4'd1);
    lookup(32'h0010_8000, 8'd9, 1'b0);
    expectRsp("R7 beyond pair", 1, S_MISS, 32'h0, 0, 0, 0, 4'd0);
  endtask

  task automatic testMultiHit();
    putEntry(4'd5, 32'h0080_0000, 8'd0, 1'b1, 16'h0, 32'h5000_0000, 32'h5100_0000, 1, 1, 1, 1);
    putEntry(4'd2, 32'h0080_0000, 8'd1, 1'b0, 16'h0, 32'h4000_0000, 32'h4100_0000, 1, 1, 1, 1);
    lookup(32'h0080_0010, 8'd1, 1'b0);
    expectRsp("R9 lowest index wins", 1, S_HIT, 32'h4000_0010, 1, 1, 1, 4'd2);
    lookup(32'h0080_0010, 8'd2, 1'b0);
    expectRsp("R9 single match no flag", 1, S_HIT, 32'h5000_0010, 1, 1, 0, 4'd5);
  endtask

  task automatic testTiming();
    @(negedge clk);
    expectRsp("R10 idle cycle", 0, S_HIT, 32'h5000_0010, 1, 1, 0, 4'd5);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd7; wrVpn = 32'h0900_0000; wrAsid = 8'd1; wrGlobal = 1'b0;
    wrMask = 16'h0; wrFrame0 = 32'h7000_0000; wrFrame1 = 32'h7100_0000;
    wrValid0 = 1'b1; wrValid1 = 1'b1; wrDirty0 = 1'b1; wrDirty1 = 1'b1;
    lkValid = 1'b1; lkAddr = 32'h0900_0044; lkAsid = 8'd1; lkStore = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; lkValid = 1'b0;
    expectRsp("R10 lookup during write sees old", 1, S_MISS, 32'h0, 0, 0, 0, 4'd0);
    lookup(32'h0900_0044, 8'd1, 1'b0);
    expectRsp("R10 R11 written entry visible", 1, S_HIT, 32'h7000_0044, 1, 1, 0, 4'd7);
  endtask

  task automatic testOverwrite();
    putEntry(4'd0, 32'h0000_4000, 8'd7, 1'b0, 16'h0, 32'h6000_0000, 32'h6100_0000, 1, 1, 0, 0);
    lookup(32'h0000_4123, 8'd5, 1'b0);
    expectRsp("R11 old identifier gone", 1, S_MISS, 32'h0, 0, 0, 0, 4'd0);
    lookup(32'h0000_4123, 8'd7, 1'b0);
    expectRsp("R11 R8 new frame read only", 1, S_HIT, 32'h6000_0123, 1, 0, 0, 4'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSmallPages();
    testLargePages();
    testMultiHit();
    testTiming();
    testOverwrite();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule